// File: doc/BRIEF.md
# Counter-Based LRU Replacement Unit

This unit holds the recency state of a set-associative cache with 2^k ways per set. Every way of every set owns a k-bit age counter, where age 0 marks the most recently touched block and the highest age marks the least recently touched one. For each access, the cache controller presents the set index, a hit flag, the way that hit, and the valid bits of that set's ways. The unit then updates that set's counters on the next rising clock edge. On a miss it names the way to fill in the same cycle, with no added delay.

On a miss, an empty way is always preferred: the lowest-numbered invalid way is filled. When every way holds a block, the way with the top age is evicted. Ways that are invalid keep their counter frozen. A cache-wide invalidate clears every counter, and so does reset. Any set's counters can be read back at any time through a combinational read port, so the state can be checked from outside.

Top module: `lru_age_unit`

## Requirements
- R1: After reset, every counter of every set reads 0 on the read port.
- R2: A hit on way h sets the age of h to 0. Every valid way whose age is strictly lower than the old age of h gains 1.
- R3: On a hit, valid ways with an age higher than the old age of h keep their age. Invalid ways keep their age whatever its value.
- R4: On a miss where at least one valid bit is 0, the victim output names the lowest-numbered invalid way, combinationally in the cycle of the strobe.
- R5: After a miss that fills an empty way, that way's age is 0. Every other valid way gains 1, and every invalid way keeps its age.
- R6: On a miss with all valid bits set, the victim is the way whose age is 2^k-1. After the update, that way's age is 0 and every other way gains 1.
- R7: A flush clears every counter of every set at the next rising edge. It takes priority over an access strobe in the same cycle.
- R8: Without a strobe or a flush, no counter changes. An access changes only the counters of the set it addresses.
- R9: The read port returns the counters of the set named by the read index, combinationally. Way w sits at bits [w*k +: k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear all counters (cache-wide invalidate) |
| acc_en_i | input | 1 | Access strobe |
| acc_set_i | input | SET_BITS | Set index of the access |
| acc_hit_i | input | 1 | 1 for a hit, 0 for a miss |
| acc_way_i | input | WAY_BITS | Way that hit (used on hits only) |
| acc_valid_i | input | 2^WAY_BITS | Valid bits of the addressed set's ways |
| victim_o | output | WAY_BITS | Way to fill on a miss |
| rd_set_i | input | SET_BITS | Set index for the read port |
| rd_ages_o | output | 2^WAY_BITS*WAY_BITS | Age counters of the read set, way w at [w*k +: k] |

## Verification
The victim is due in the strobe cycle itself. The bench drives inputs at the falling edge and compares the victim one time unit later, before the rising edge that consumes the strobe. New counter values appear after that rising edge. The driver queues the expected row once that edge has passed, and the monitor pops it at the following falling edge, points the read port at the set and compares one time unit later. The driver issues the next access only after the queue has drained, so each expectation matches exactly one update. Flush and idle checks queue one row per set, which also covers sets that the access did not address.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Kind of counter update applied to the addressed set
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HIT   = 2'd1,
        ACC_FILL  = 2'd2,
        ACC_EVICT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int WAY_BITS = 2,
    localparam int WAYS = 1 << WAY_BITS,
    localparam int ROW_W = WAYS * WAY_BITS
) (
    input  logic [ROW_W-1:0]    ages_i,
    input  logic [WAYS-1:0]     valid_i,
    output logic                has_empty_o,
    output logic [WAY_BITS-1:0] victim_o
);

    logic [WAY_BITS-1:0] empty_way;
    logic [WAY_BITS-1:0] oldest_way;
    logic [WAY_BITS-1:0] oldest_age;

    // Lowest-numbered invalid way: scan downward so the last hit wins
    always_comb begin
        has_empty_o = 1'b0;
        empty_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                has_empty_o = 1'b1;
                empty_way   = WAY_BITS'(w);
            end
        end
    end

    // Way holding the highest age; ties resolve to the lower index
    always_comb begin
        oldest_way = '0;
        oldest_age = ages_i[WAY_BITS-1:0];
        for (int w = 1; w < WAYS; w++) begin
            if (ages_i[w*WAY_BITS +: WAY_BITS] > oldest_age) begin
                oldest_age = ages_i[w*WAY_BITS +: WAY_BITS];
                oldest_way = WAY_BITS'(w);
            end
        end
    end

    assign victim_o = has_empty_o ? empty_way : oldest_way;

endmodule

// File: rtl/lru_age_next.sv
module lru_age_next
    import lru_pkg::*;
#(
    parameter int WAY_BITS = 2,
    localparam int WAYS = 1 << WAY_BITS,
    localparam int ROW_W = WAYS * WAY_BITS
) (
    input  logic [ROW_W-1:0]    ages_i,
    input  logic [WAYS-1:0]     valid_i,
    input  acc_kind_e           kind_i,
    input  logic [WAY_BITS-1:0] tgt_i,
    output logic [ROW_W-1:0]    ages_o
);

    localparam logic [WAY_BITS-1:0] AGE_MAX = '1;

    logic [WAY_BITS-1:0] ref_age;

    assign ref_age = ages_i[tgt_i*WAY_BITS +: WAY_BITS];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [WAY_BITS-1:0] cur_age;
        logic [WAY_BITS-1:0] nxt_age;
        logic                younger;
        logic                bump;

        assign cur_age = ages_i[g*WAY_BITS +: WAY_BITS];
        // On a hit only ways younger than the referenced one age;
        // on a fill or eviction every other occupied way ages.
        assign younger = (kind_i != ACC_HIT) || (cur_age < ref_age);
        assign bump    = valid_i[g] && younger && (cur_age != AGE_MAX);

        always_comb begin
            if (kind_i == ACC_IDLE) begin
                nxt_age = cur_age;
            end else if (tgt_i == WAY_BITS'(g)) begin
                nxt_age = '0;
            end else if (bump) begin
                nxt_age = cur_age + 1'b1;
            end else begin
                nxt_age = cur_age;
            end
        end

        assign ages_o[g*WAY_BITS +: WAY_BITS] = nxt_age;
    end

endmodule

// File: rtl/lru_age_unit.sv
module lru_age_unit
    import lru_pkg::*;
#(
    parameter int WAY_BITS = 2,
    parameter int SET_BITS = 3,
    localparam int WAYS = 1 << WAY_BITS,
    localparam int NUM_SETS = 1 << SET_BITS,
    localparam int ROW_W = WAYS * WAY_BITS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                flush_i,
    input  logic                acc_en_i,
    input  logic [SET_BITS-1:0] acc_set_i,
    input  logic                acc_hit_i,
    input  logic [WAY_BITS-1:0] acc_way_i,
    input  logic [WAYS-1:0]     acc_valid_i,
    output logic [WAY_BITS-1:0] victim_o,
    input  logic [SET_BITS-1:0] rd_set_i,
    output logic [ROW_W-1:0]    rd_ages_o
);

    typedef struct packed {
        logic [NUM_SETS-1:0][ROW_W-1:0] ages;
    } lru_state_t;

    lru_state_t st_d, st_q;

    logic [NUM_SETS-1:0][ROW_W-1:0] ages_q;
    logic [ROW_W-1:0]    cur_row;
    logic [ROW_W-1:0]    new_row;
    logic                has_empty;
    logic [WAY_BITS-1:0] pick_way;
    logic [WAY_BITS-1:0] tgt_way;
    acc_kind_e           kind;

    assign ages_q  = st_q.ages;
    assign cur_row = st_q.ages[acc_set_i];

    lru_victim_pick #(.WAY_BITS(WAY_BITS)) u_pick (
        .ages_i      (cur_row),
        .valid_i     (acc_valid_i),
        .has_empty_o (has_empty),
        .victim_o    (pick_way)
    );

    always_comb begin
        if (!acc_en_i) begin
            kind = ACC_IDLE;
        end else if (acc_hit_i) begin
            kind = ACC_HIT;
        end else if (has_empty) begin
            kind = ACC_FILL;
        end else begin
            kind = ACC_EVICT;
        end
    end

    assign tgt_way = acc_hit_i ? acc_way_i : pick_way;

    lru_age_next #(.WAY_BITS(WAY_BITS)) u_next (
        .ages_i  (cur_row),
        .valid_i (acc_valid_i),
        .kind_i  (kind),
        .tgt_i   (tgt_way),
        .ages_o  (new_row)
    );

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.ages = '0;
        end else if (acc_en_i) begin
            st_d.ages[acc_set_i] = new_row;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign victim_o  = pick_way;
    assign rd_ages_o = st_q.ages[rd_set_i];

endmodule

// File: rtl/lru_age_chk.sv
module lru_age_chk #(
    parameter int WAY_BITS = 2,
    parameter int SET_BITS = 3,
    localparam int WAYS = 1 << WAY_BITS,
    localparam int NUM_SETS = 1 << SET_BITS,
    localparam int ROW_W = WAYS * WAY_BITS
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic                           flush_i,
    input logic                           acc_en_i,
    input logic [SET_BITS-1:0]            acc_set_i,
    input logic                           acc_hit_i,
    input logic [WAYS-1:0]                acc_valid_i,
    input logic [WAY_BITS-1:0]            victim_o,
    input logic [NUM_SETS-1:0][ROW_W-1:0] ages_q,
    input logic [WAY_BITS-1:0]            tgt_way
);

    function automatic logic [WAY_BITS-1:0] age_of(input logic [ROW_W-1:0] row,
                                                   input logic [WAY_BITS-1:0] w);
        return row[w*WAY_BITS +: WAY_BITS];
    endfunction

    // R7
    flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (ages_q == '0));

    // R2 R5 R6
    target_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_en_i && !flush_i) |=>
            (age_of(ages_q[$past(acc_set_i)], $past(tgt_way)) == '0));

    // R8
    idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!acc_en_i && !flush_i) |=> $stable(ages_q));

    logic                vic_is_oldest;
    logic [ROW_W-1:0]    row_now;

    always_comb begin
        row_now       = ages_q[acc_set_i];
        vic_is_oldest = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (age_of(row_now, WAY_BITS'(w)) > age_of(row_now, victim_o)) begin
                vic_is_oldest = 1'b0;
            end
        end
        if (rst_ni === 1'b1 && acc_en_i === 1'b1 && acc_hit_i === 1'b0) begin
            if (&acc_valid_i) begin
                // R6
                full_victim_chk: assert (vic_is_oldest);
            end else begin
                // R4
                empty_victim_chk: assert (!acc_valid_i[victim_o]);
            end
        end
    end

endmodule

bind lru_age_unit lru_age_chk #(
    .WAY_BITS (WAY_BITS),
    .SET_BITS (SET_BITS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .acc_en_i    (acc_en_i),
    .acc_set_i   (acc_set_i),
    .acc_hit_i   (acc_hit_i),
    .acc_valid_i (acc_valid_i),
    .victim_o    (victim_o),
    .ages_q      (ages_q),
    .tgt_way     (tgt_way)
);

// File: tb/tb_lru_age_unit.sv
module tb_lru_age_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WAY_BITS = 2;
    localparam int SET_BITS = 3;
    localparam int WAYS = 1 << WAY_BITS;
    localparam int NSETS = 1 << SET_BITS;
    localparam int ROW_W = WAYS * WAY_BITS;
    localparam int AMAX = WAYS - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                flush = 1'b0;
    logic                acc_en = 1'b0;
    logic [SET_BITS-1:0] acc_set = '0;
    logic                acc_hit = 1'b0;
    logic [WAY_BITS-1:0] acc_way = '0;
    logic [WAYS-1:0]     acc_valid = '0;
    logic [WAY_BITS-1:0] victim;
    logic [SET_BITS-1:0] rd_set = '0;
    logic [ROW_W-1:0]    rd_ages;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lru_age_unit #(.WAY_BITS(WAY_BITS), .SET_BITS(SET_BITS)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .flush_i     (flush),
        .acc_en_i    (acc_en),
        .acc_set_i   (acc_set),
        .acc_hit_i   (acc_hit),
        .acc_way_i   (acc_way),
        .acc_valid_i (acc_valid),
        .victim_o    (victim),
        .rd_set_i    (rd_set),
        .rd_ages_o   (rd_ages)
    );

    typedef struct {
        int               set;
        logic [ROW_W-1:0] ages;
        string            req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    int    m_age[NSETS][WAYS];
    bit    m_val[NSETS][WAYS];

    task automatic chk(input bit ok, input string req,
                       input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [ROW_W-1:0] model_row(input int s);
        logic [ROW_W-1:0] r = '0;
        for (int w = 0; w < WAYS; w++) r[w*WAY_BITS +: WAY_BITS] = WAY_BITS'(m_age[s][w]);
        return r;
    endfunction

    task automatic push_row(input int s, input string req);
        item_t it;
        it.set = s;
        it.ages = model_row(s);
        it.req = req;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0);
    endtask

    task automatic scan_all(input string req);
        for (int s = 0; s < NSETS; s++) push_row(s, req);
        drain();
    endtask

    // One access; expected victim and counters from the requirements
    task automatic access(input int s, input bit hit, input int way);
        int tgt;
        int ref_age;
        bit empty;
        @(negedge clk);
        acc_en = 1'b1;
        acc_set = SET_BITS'(s);
        acc_hit = hit;
        acc_way = WAY_BITS'(way);
        for (int w = 0; w < WAYS; w++) acc_valid[w] = m_val[s][w];
        empty = 1'b0;
        tgt = 0;
        if (hit) begin
            tgt = way;
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) begin empty = 1'b1; tgt = w; end
            if (!empty) begin
                for (int w = 0; w < WAYS; w++) if (m_age[s][w] == AMAX) tgt = w;
            end
        end
        #1;
        if (!hit) begin
            if (empty) chk(victim == WAY_BITS'(tgt), "R4 victim", ROW_W'(victim), ROW_W'(tgt));
            else       chk(victim == WAY_BITS'(tgt), "R6 victim", ROW_W'(victim), ROW_W'(tgt));
        end
        ref_age = m_age[s][tgt];
        for (int w = 0; w < WAYS; w++) begin
            if (w == tgt) m_age[s][w] = 0;
            else if (m_val[s][w] && (!hit || m_age[s][w] < ref_age) && m_age[s][w] < AMAX)
                m_age[s][w]++;
        end
        m_val[s][tgt] = 1'b1;
        @(posedge clk);
        #1;
        acc_en = 1'b0;
        if (hit) push_row(s, "R2 R3 hit counters");
        else if (empty) push_row(s, "R5 fill counters");
        else push_row(s, "R6 evict counters");
        drain();
    endtask

    // Monitor: pops expectations and compares them on the read port
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                rd_set = SET_BITS'(it.set);
                #1;
                chk(rd_ages === it.ages, it.req, rd_ages, it.ages);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < WAYS; w++) begin m_age[s][w] = 0; m_val[s][w] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        scan_all("R1 reset state");

        // Fill set 2 from empty, then reorder recency with hits
        for (int i = 0; i < WAYS; i++) access(2, 1'b0, 0);
        access(2, 1'b1, 3);
        access(2, 1'b1, 2);
        access(2, 1'b1, 0);
        access(2, 1'b1, 1);
        // ages w0..w3 = 1,0,2,3; hit on the age-2 way gives 2,1,0,3
        access(2, 1'b1, 2);
        begin
            item_t it;
            it.set = 2; it.ages = 8'hC6; it.req = "R2 R3 worked example";
            q.push_back(it);
            drain();
        end
        // Hit on the youngest way changes nothing else
        access(2, 1'b1, 2);
        // Full set misses evict the oldest way
        access(2, 1'b0, 0);
        access(2, 1'b0, 0);

        // Set 5: partial fill, one way invalidated externally
        access(5, 1'b0, 0);
        access(5, 1'b0, 0);
        access(5, 1'b0, 0);
        m_val[5][1] = 1'b0;
        access(5, 1'b1, 0);
        access(5, 1'b0, 0);
        access(5, 1'b0, 0);
        access(5, 1'b0, 0);

        // Idle cycles then a full scan of all sets
        repeat (4) @(posedge clk);
        scan_all("R8 R9 idle and other sets");

        // Flush together with a strobe: flush wins
        @(negedge clk);
        flush = 1'b1;
        acc_en = 1'b1;
        acc_set = 3'd2;
        acc_hit = 1'b1;
        acc_way = 2'd3;
        acc_valid = '1;
        @(posedge clk);
        #1;
        flush = 1'b0;
        acc_en = 1'b0;
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < WAYS; w++) begin m_age[s][w] = 0; m_val[s][w] = 1'b0; end
        scan_all("R7 flush priority");

        access(2, 1'b0, 0);
        access(2, 1'b0, 0);
        scan_all("R8 R9 final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule